// File: doc/BRIEF.md
# Glitch-Free Gated Clock Divider

This block divides a master clock by a programmable integer ratio and gates the divided clock with an output-enable input that may change at any time. The enable is captured by a register on the rising master edge, and only that captured copy controls the output. The asynchronous pin never reaches the output. Enabling and disabling therefore only start or stop whole pulses. A high or low phase is never cut short.

For ratios of two or more, a counter builds each period from a full high phase followed by a full low phase. A period is only repeated if the captured enable is still set when the previous period ends. For a ratio of one, the output is the master clock itself, passed through a gate. That gate is updated on the falling master edge, so it only opens or closes while the clock is low. The ratio is held in a register that loads only when the block is idle and the captured enable is clear. A ratio change therefore never alters a running output.

Top module: `gated_divider`

## Requirements
- R1: The enable input is captured on the rising master edge, and the output follows only the captured value. If enable is set before edge k, the captured copy is set after edge k.
- R2: For a ratio N of 2 or more, every output period is exactly N master cycles. The output is high for floor(N/2) cycles and low for the remaining cycles.
- R3: If the enable input is first captured high at edge k, the output's first rising edge is at master edge k+1. This is one to two master periods after the enable input rises.
- R4: If the captured enable falls while the output is high, that high phase completes at full width. The low phase of the same period completes at full width. The output then stays low.
- R5: At the edge that ends each period, the block checks the captured enable. If it is set, one more full period follows. If it is clear, the output stops. An enable that falls during the last master cycle of a period therefore lets exactly one more complete pulse out.
- R6: For a ratio of 1, the output equals the master clock while the gate is open. The gate takes the captured enable on the falling master edge. The high phase that starts at the first edge where the captured enable is clear is still emitted whole. No pulse follows it.
- R7: A ratio input of 0 behaves as a ratio of 1.
- R8: The stored ratio loads from the input only when no pulse is running and the captured enable is clear. Ratio changes made while the output is enabled, or while a pulse is completing, do not affect the output.
- R9: An active-low synchronous reset holds the output low and clears the captured enable, the counter and the gate. The stored ratio resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| out_en | input | 1 | Output enable, asynchronous to clk |
| ratio | input | RATIO_W | Divide ratio N (0 is treated as 1) |
| clk_out | output | 1 | Gated divided clock |

## Verification
The sharpest coincidence is a disable that lands on a period boundary. The enable is dropped during the last master cycle of a period, so the edge that ends the period still sees the old captured value. That edge must start one more full period, not a truncated one. The bench runs this case for ratios 2 and 3, and runs neighbouring cases where the enable falls one or more cycles earlier. In every run, the ratio input is changed at the same moments the enable is changing. The scoreboard checks the output cycle by cycle, in both the high and the low half of each master period. It therefore catches a pulse that is cut short, a pulse that is emitted one period too many, and a ratio change that leaks into a running output.

// File: rtl/gated_divider_pkg.sv
// Shared types for the gated divider.
package gated_divider_pkg;
    // Output path selected by the stored ratio.
    typedef enum logic {
        MODE_GATE = 1'b0,   // ratio 1: master clock through a gate
        MODE_DIV  = 1'b1    // ratio >= 2: counter-built period
    } path_mode_e;
endpackage

// File: rtl/gdiv_sampler.sv
// Captures the asynchronous output enable on the rising master edge.
// Assumes: the captured copy is the only enable that any later logic uses.
module gdiv_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic en_async,
    output logic en_q
);
    // capture the enable once per master cycle
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_async;
    end
endmodule

// File: rtl/gdiv_ratio.sv
// Holds the divide ratio and derives the output path.
// Assumes: busy covers every cycle in which a pulse may still be running.
module gdiv_ratio
    import gated_divider_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_in,
    input  logic         busy,
    input  logic         en_q,
    output logic [W-1:0] ratio_q,
    output path_mode_e   mode
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] ratio_fixed;

    // map a zero ratio onto divide-by-one
    assign ratio_fixed = (ratio_in == '0) ? ONE : ratio_in;

    // load only while idle and not about to start
    always_ff @(posedge clk) begin
        if (!rst_n)              ratio_q <= ONE;
        else if (!busy && !en_q) ratio_q <= ratio_fixed;
    end

    // choose the output path from the stored ratio
    assign mode = (ratio_q == ONE) ? MODE_GATE : MODE_DIV;

    p_ratio_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || en_q) |=> $stable(ratio_q));
endmodule

// File: rtl/gdiv_counter.sv
// Builds whole periods for ratios of two or more: high for floor(N/2)
// cycles, then low for the rest. At each period end it either restarts
// or stops, depending on the captured enable.
// Assumes: ratio_q is stable while active (guaranteed by gdiv_ratio).
module gdiv_counter
    import gated_divider_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_q,
    input  path_mode_e   mode,
    input  logic [W-1:0] ratio_q,
    output logic         div_q,
    output logic         active
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] half;
    logic [W-1:0] cnt_inc;
    logic         period_end;

    // derive high length, next count and the last cycle of a period
    assign half       = ratio_q >> 1;
    assign cnt_inc    = cnt_q + 1'b1;
    assign period_end = (cnt_q == ratio_q - 1'b1);

    // period counter with start, restart and stop decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt_q  <= '0;
            div_q  <= 1'b0;
        end else if (!active) begin
            if (en_q && mode == MODE_DIV) begin
                active <= 1'b1;
                cnt_q  <= '0;
                div_q  <= 1'b1;
            end
        end else if (period_end) begin
            cnt_q <= '0;
            if (en_q) begin
                div_q <= 1'b1;
            end else begin
                active <= 1'b0;
                div_q  <= 1'b0;
            end
        end else begin
            cnt_q <= cnt_inc;
            div_q <= (cnt_inc < half);
        end
    end

    p_rise_needs_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_q) |-> $past(en_q));
    p_fall_at_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_q) |-> (active && cnt_q == half));
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < ratio_q));
    p_stop_from_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> !$past(div_q));
    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !div_q);
endmodule

// File: rtl/gdiv_outgate.sv
// Drives the output. For ratio 1, the master clock passes through a gate
// that changes only on the falling edge. Otherwise the counter output
// passes through.
// Assumes: mode changes only while both paths are idle and low.
module gdiv_outgate
    import gated_divider_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_q,
    input  path_mode_e mode,
    input  logic       div_q,
    output logic       gate_q,
    output logic       clk_out
);
    // open or close the gate only while the master clock is low
    always_ff @(negedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= en_q && (mode == MODE_GATE);
    end

    // select the output path
    assign clk_out = (mode == MODE_GATE) ? (clk & gate_q) : div_q;

    p_gate_mode_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> (mode == MODE_GATE));
    p_gate_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_GATE) |-> (gate_q == en_q));
endmodule

// File: rtl/gated_divider.sv
// Top: glitch-free gated clock divider. It captures the enable, holds
// the ratio, and builds the divided or gated output from them.
// Assumes: clk is the only clock; out_en and ratio may change at any time.
module gated_divider
    import gated_divider_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               out_en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               clk_out
);
    logic               en_q;
    logic               busy;
    logic               active;
    logic               div_q;
    logic               gate_q;
    logic [RATIO_W-1:0] ratio_q;
    path_mode_e         mode;

    // a pulse may still be running on either path
    assign busy = active | gate_q;

    gdiv_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_async (out_en),
        .en_q     (en_q)
    );

    gdiv_ratio #(.W(RATIO_W)) u_rat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_in (ratio),
        .busy     (busy),
        .en_q     (en_q),
        .ratio_q  (ratio_q),
        .mode     (mode)
    );

    gdiv_counter #(.W(RATIO_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_q    (en_q),
        .mode    (mode),
        .ratio_q (ratio_q),
        .div_q   (div_q),
        .active  (active)
    );

    gdiv_outgate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_q    (en_q),
        .mode    (mode),
        .div_q   (div_q),
        .gate_q  (gate_q),
        .clk_out (clk_out)
    );

    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (!div_q && !en_q && !active));
endmodule

// File: tb/sim_gated_divider.sv
`timescale 1ns/100ps
module sim_gated_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       out_en = 1'b1;
    logic [7:0] ratio = 8'd4;
    logic       clk_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  hi;
        logic  lo;
        string req;
    } exp_t;
    exp_t scb[$];

    gated_divider #(.RATIO_W(8)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .out_en  (out_en),
        .ratio   (ratio),
        .clk_out (clk_out)
    );

    always #2.5 clk = ~clk;

    // Driver step: push the expected output for the cycle that starts at
    // this edge, then drive the inputs for the next edge.
    task automatic step(input logic rst, input logic en, input logic [7:0] r,
                        input logic hi, input logic lo, input string req);
        @(posedge clk);
        scb.push_back('{hi: hi, lo: lo, req: req});
        #2;
        rst_n  = rst;
        out_en = en;
        ratio  = r;
    endtask

    // Divide path run (N >= 2): the enable falls at cycle dis_c of the
    // last period. The ratio input is scrambled during the run (R8).
    task automatic run_div(input int n, input int periods, input int dis_c,
                           input string req);
        logic [7:0] scr;
        logic       e;
        scr = 8'(n + 3);
        step(1, 0, 8'(n), 0, 0, "R1");
        step(1, 1, 8'(n), 0, 0, "R3");
        step(1, 1, scr, 0, 0, "R3");
        for (int p = 0; p < periods; p++) begin
            for (int c = 0; c < n; c++) begin
                e = !((p == periods - 1) && (c >= dis_c));
                step(1, e, scr, (c < n / 2), (c < n / 2),
                     (p == periods - 1) ? req : "R2_R8");
            end
        end
        if (dis_c == n - 1) begin
            // disable missed the period-end edge: one more whole period (R5)
            for (int c = 0; c < n; c++)
                step(1, 0, scr, (c < n / 2), (c < n / 2), "R5");
        end
        for (int i = 0; i < 3; i++)
            step(1, 0, 8'(n), 0, 0, req);
    endtask

    // Gate path run (ratio 1 or 0): output equals clk while open (R6, R7).
    task automatic run_gate(input logic [7:0] r, input int cycles,
                            input string req);
        step(1, 0, r, 0, 0, req);
        step(1, 1, r, 0, 0, "R3");
        step(1, 1, 8'd5, 0, 0, "R3");
        for (int i = 0; i < cycles; i++)
            step(1, (i != cycles - 1), 8'd5, 1, 0, req);
        step(1, 0, 8'd5, 1, 0, "R6");
        for (int i = 0; i < 3; i++)
            step(1, 0, r, 0, 0, req);
    endtask

    // Monitor: pop one item per cycle; check the high and low halves.
    always begin
        exp_t it;
        @(posedge clk);
        #1;
        if (scb.size() > 0) begin
            it = scb.pop_front();
            checks++;
            if (clk_out !== it.hi) begin
                errors++;
                $display("FAIL %s high half: got %b expected %b at %0t",
                         it.req, clk_out, it.hi, $time);
            end
            #2.5;
            checks++;
            if (clk_out !== it.lo) begin
                errors++;
                $display("FAIL %s low half: got %b expected %b at %0t",
                         it.req, clk_out, it.lo, $time);
            end
        end
    end

    // Stimulus: reset state, then enable and disable corner cases.
    initial begin
        // R9: output stays low in reset even with enable set
        step(0, 1, 8'd4, 0, 0, "R9");
        step(0, 1, 8'd4, 0, 0, "R9");
        step(1, 1, 8'd4, 0, 0, "R9");
        step(1, 1, 8'd4, 0, 0, "R9");
        // R3: first rise one edge after the first capture, N = 4
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 4; c++)
                step(1, !(p == 1 && c >= 2), 8'd4, (c < 2), (c < 2), "R2");
        for (int i = 0; i < 3; i++) step(1, 0, 8'd4, 0, 0, "R5");
        run_div(5, 2, 0, "R4");   // disable during high phase
        run_div(6, 2, 1, "R4");   // disable late in high phase
        run_div(3, 2, 2, "R5");   // disable in last cycle: one extra period
        run_div(2, 3, 1, "R5");   // same for N = 2
        run_div(7, 2, 4, "R5");   // disable met before period end
        run_gate(8'd1, 4, "R6");
        run_gate(8'd0, 3, "R7");
        run_div(4, 1, 3, "R8");   // back from gate path, ratio reload
        while (scb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end
endmodule